// File: doc/BRIEF.md
# Latched Priority Interrupt Controller

This block collects up to 32 interrupt sources for a processor sequencer. Each request sets a bit in a pending latch. A per-bit mask register and a single global enable decide which pending bits may be serviced. Every cycle the block offers the highest-priority serviceable bit on a registered service port. Index 0 has the highest priority and index 31 the lowest.

Index 0 is the reset vector. It ignores both the mask and the global enable. A timer-zero event sets two pending bits at once, at two different priorities. Software picks the priority it wants by unmasking only one of the two. Four arithmetic exception sources are driven from sticky status flags. Each one sets its pending bit again on every cycle until software clears the flag.

Software reads and writes the pending latch, the mask and the mode register through a simple select/data port. The service port uses valid/ready:
- `svc_valid` with `svc_index` offers a vector. It is never withdrawn while its pending bit is still set.
- If a higher-priority request becomes eligible first, the offered index moves to that request. So the index is not held stable under back-pressure.
- A transfer happens in any cycle where `svc_valid` and `svc_ready` are both high. The transfer acknowledges the index shown in that cycle.
- Holding `svc_ready` low only delays the transfer. Requests keep latching while it is low.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending latch, the mask and the global enable are all zero, and `svc_valid` is low.
- R2: A request on `irq_req[n]` sets pending bit n even when that bit is masked or the global enable is off. The bit then reads back as 1 at register select 0 (pending).
- R3: `svc_index` is the lowest index whose pending bit is set and which is eligible. The service port is registered: a change to the pending latch, mask or enable is visible one clock edge after it is applied.
- R4: The global enable is bit 12 of the mode register (register select 2). While it is 0, no index other than 0 is offered.
- R5: Pending bit 0 is offered regardless of mask bit 0 and of the global enable.
- R6: Mask bit n (register select 1) gates only pending bit n, and 1 means enabled. A masked pending bit is kept and is offered once its mask bit is set.
- R7: `tmr_zero` sets pending bits 4 and 14 in the same cycle. When both are unmasked, 4 is offered first and 14 after 4 is acknowledged.
- R8: `arith_sticky[k]` sets pending bit 25+k on every cycle it is high. The sources are 25 fixed overflow, 26 float overflow, 27 float underflow and 28 invalid operation. An acknowledge does not clear the bit while the flag stays high.
- R9: A transfer (`svc_valid` and `svc_ready` both high) clears only the pending bit at `svc_index`.
- R10: A request that arrives in the same cycle as the transfer of its own index leaves that pending bit set.
- R11: A write to register select 0 replaces the pending latch. Requests arriving in the same cycle are OR-ed in on top of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 32 | One request pulse or level per index |
| tmr_zero | input | 1 | Timer reached zero; sets bits 4 and 14 |
| arith_sticky | input | 4 | Sticky arithmetic exception flags |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Write target: 0 pending, 1 mask, 2 mode |
| cfg_wdata | input | 32 | Write data |
| cfg_rd_sel | input | 2 | Read target: 0 pending, 1 mask, 2 mode, 3 zero |
| cfg_rdata | output | 32 | Read data, combinational from the selected register |
| svc_valid | output | 1 | A vector is offered |
| svc_index | output | 5 | Offered vector index |
| svc_ready | input | 1 | Consumer accepts the offered vector |

## Verification
The bench drives several kinds of input and compares the service port and the read port every clock against a behavioural model:
- Single requests, with the mask on and off and the enable on and off. These show latching apart from eligibility.
- Several requests set in one cycle, and a later higher-priority arrival. These show lowest-index selection and preemption.
- Timer and sticky-flag stimulus. These show the two-bit timer event, and show that a held flag re-asserts its bit against an acknowledge.
- Collisions: an acknowledge or a register write landing in the same cycle as a fresh request. These show that the set wins over the clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_MASK = 2'd1,
    SEL_MODE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_src_map.sv
module irq_src_map #(
  parameter int N_SRC      = 32,
  parameter int TMR_HI_IDX = 4,
  parameter int TMR_LO_IDX = 14,
  parameter int ARITH_BASE = 25,
  parameter int N_ARITH    = 4
) (
  input  logic [N_SRC-1:0]   irq_req,
  input  logic               tmr_zero,
  input  logic [N_ARITH-1:0] arith_sticky,
  output logic [N_SRC-1:0]   set_vec
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic from_tmr;
    logic from_arith;
    if (g == TMR_HI_IDX || g == TMR_LO_IDX) begin : g_tmr
      assign from_tmr = tmr_zero;
    end else begin : g_ntmr
      assign from_tmr = 1'b0;
    end
    if (g >= ARITH_BASE && g < ARITH_BASE + N_ARITH) begin : g_ar
      assign from_arith = arith_sticky[g - ARITH_BASE];
    end else begin : g_nar
      assign from_arith = 1'b0;
    end
    assign set_vec[g] = irq_req[g] | from_tmr | from_arith;
  end
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int N_SRC = 32,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [N_SRC-1:0] wdata,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [N_SRC-1:0] set_vec,
  output logic [N_SRC-1:0] pend_q,
  output logic [N_SRC-1:0] pend_d
);
  logic [N_SRC-1:0] base;
  logic [N_SRC-1:0] clr_vec;

  always_comb begin
    base    = wr_en ? wdata : pend_q;
    clr_vec = '0;
    if (clr_en) clr_vec[clr_idx] = 1'b1;
    pend_d  = (base & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_wr,
  input  logic [N_SRC-1:0] mask_wdata,
  input  logic             mode_wr,
  input  logic             en_wdata,
  output logic [N_SRC-1:0] mask_q,
  output logic [N_SRC-1:0] mask_d,
  output logic             en_q,
  output logic             en_d
);
  assign mask_d = mask_wr ? mask_wdata : mask_q;
  assign en_d   = mode_wr ? en_wdata : en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      mask_q <= mask_d;
      en_q   <= en_d;
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int N_SRC = 32,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] elig,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = |elig;
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC       = 32,
  parameter int TMR_HI_IDX  = 4,
  parameter int TMR_LO_IDX  = 14,
  parameter int ARITH_BASE  = 25,
  parameter int N_ARITH     = 4,
  parameter int GEN_EN_BIT  = 12,
  localparam int IDX_W      = $clog2(N_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   irq_req,
  input  logic               tmr_zero,
  input  logic [N_ARITH-1:0] arith_sticky,
  input  logic               cfg_wr_en,
  input  logic [1:0]         cfg_wr_sel,
  input  logic [N_SRC-1:0]   cfg_wdata,
  input  logic [1:0]         cfg_rd_sel,
  output logic [N_SRC-1:0]   cfg_rdata,
  output logic               svc_valid,
  output logic [IDX_W-1:0]   svc_index,
  input  logic               svc_ready
);
  localparam logic [N_SRC-1:0] RST_VEC = N_SRC'(1);

  reg_sel_e         wr_sel;
  reg_sel_e         rd_sel;
  logic [N_SRC-1:0] set_vec;
  logic [N_SRC-1:0] pend_q, pend_d;
  logic [N_SRC-1:0] mask_q, mask_d;
  logic             en_q, en_d;
  logic [N_SRC-1:0] elig;
  logic             sel_hit;
  logic [IDX_W-1:0] sel_idx;
  logic             xfer;

  assign wr_sel = reg_sel_e'(cfg_wr_sel);
  assign rd_sel = reg_sel_e'(cfg_rd_sel);
  assign xfer   = svc_valid & svc_ready;

  irq_src_map #(
    .N_SRC(N_SRC), .TMR_HI_IDX(TMR_HI_IDX), .TMR_LO_IDX(TMR_LO_IDX),
    .ARITH_BASE(ARITH_BASE), .N_ARITH(N_ARITH)
  ) src_map_i (
    .irq_req(irq_req), .tmr_zero(tmr_zero), .arith_sticky(arith_sticky),
    .set_vec(set_vec)
  );

  irq_pend_latch #(.N_SRC(N_SRC)) pend_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en && wr_sel == SEL_PEND), .wdata(cfg_wdata),
    .clr_en(xfer), .clr_idx(svc_index), .set_vec(set_vec),
    .pend_q(pend_q), .pend_d(pend_d)
  );

  irq_cfg_regs #(.N_SRC(N_SRC)) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .mask_wr(cfg_wr_en && wr_sel == SEL_MASK), .mask_wdata(cfg_wdata),
    .mode_wr(cfg_wr_en && wr_sel == SEL_MODE), .en_wdata(cfg_wdata[GEN_EN_BIT]),
    .mask_q(mask_q), .mask_d(mask_d), .en_q(en_q), .en_d(en_d)
  );

  // Index 0 bypasses mask and global enable.
  assign elig = pend_d & ((mask_d & {N_SRC{en_d}}) | RST_VEC);

  irq_prio_sel #(.N_SRC(N_SRC)) sel_i (
    .elig(elig), .hit(sel_hit), .idx(sel_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_valid <= 1'b0;
      svc_index <= '0;
    end else begin
      svc_valid <= sel_hit;
      svc_index <= sel_idx;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (rd_sel)
      SEL_PEND: cfg_rdata = pend_q;
      SEL_MASK: cfg_rdata = mask_q;
      SEL_MODE: cfg_rdata[GEN_EN_BIT] = en_q;
      default:  cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N_SRC      = 32,
  parameter int TMR_HI_IDX = 4,
  parameter int TMR_LO_IDX = 14,
  parameter int ARITH_BASE = 25,
  parameter int N_ARITH    = 4,
  localparam int IDX_W     = $clog2(N_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tmr_zero,
  input logic [N_ARITH-1:0] arith_sticky,
  input logic               cfg_wr_en,
  input logic [1:0]         cfg_wr_sel,
  input logic [N_SRC-1:0]   set_vec,
  input logic [N_SRC-1:0]   pend_q,
  input logic [N_SRC-1:0]   mask_q,
  input logic               en_q,
  input logic               svc_valid,
  input logic [IDX_W-1:0]   svc_index,
  input logic               svc_ready
);
  logic [N_SRC-1:0] c_elig;
  logic [N_SRC-1:0] c_below;
  logic             c_pwr;

  always_comb begin
    c_elig  = pend_q & ((mask_q & {N_SRC{en_q}}) | N_SRC'(1));
    c_below = (N_SRC'(1) << svc_index) - N_SRC'(1);
    c_pwr   = cfg_wr_en && cfg_wr_sel == 2'd0;
  end

  p_offer_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> pend_q[svc_index]);
  p_lowest_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> (c_elig & c_below) == '0);
  p_none_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_elig == '0) |-> !svc_valid);
  p_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && svc_index != '0) |-> en_q);
  p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && svc_index != '0) |-> mask_q[svc_index]);
  p_reset_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[0] |-> (svc_valid && svc_index == '0));
  p_timer_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_zero |=> (pend_q[TMR_HI_IDX] && pend_q[TMR_LO_IDX]));
  p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && svc_ready && !set_vec[svc_index] && !c_pwr)
      |=> !pend_q[$past(svc_index)]);
  p_ack_vs_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && svc_ready && set_vec[svc_index])
      |=> pend_q[$past(svc_index)]);

  for (genvar k = 0; k < N_ARITH; k++) begin : g_sticky
    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      arith_sticky[k] |=> pend_q[ARITH_BASE + k]);
  end
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(
  .N_SRC(N_SRC), .TMR_HI_IDX(TMR_HI_IDX), .TMR_LO_IDX(TMR_LO_IDX),
  .ARITH_BASE(ARITH_BASE), .N_ARITH(N_ARITH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tmr_zero(tmr_zero), .arith_sticky(arith_sticky),
  .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .set_vec(set_vec),
  .pend_q(pend_q), .mask_q(mask_q), .en_q(en_q),
  .svc_valid(svc_valid), .svc_index(svc_index), .svc_ready(svc_ready)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_req;
  logic        tmr_zero;
  logic [3:0]  arith_sticky;
  logic        cfg_wr_en;
  logic [1:0]  cfg_wr_sel;
  logic [31:0] cfg_wdata;
  logic [1:0]  cfg_rd_sel;
  logic [31:0] cfg_rdata;
  logic        svc_valid;
  logic [4:0]  svc_index;
  logic        svc_ready;

  always #5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .tmr_zero(tmr_zero),
    .arith_sticky(arith_sticky), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wdata(cfg_wdata), .cfg_rd_sel(cfg_rd_sel), .cfg_rdata(cfg_rdata),
    .svc_valid(svc_valid), .svc_index(svc_index), .svc_ready(svc_ready)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  // Behavioural reference state
  bit [31:0] m_pend, m_mask;
  bit        m_en, m_valid;
  int        m_idx;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit [31:0] m_read(bit [1:0] sel);
    case (sel)
      2'd0: return m_pend;
      2'd1: return m_mask;
      2'd2: return {19'd0, m_en, 12'd0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_step();
    bit [31:0] setv, base;
    setv = irq_req | {3'd0, arith_sticky, 25'd0};
    if (tmr_zero) setv = setv | (32'd1 << 4) | (32'd1 << 14);
    base = (cfg_wr_en && cfg_wr_sel == 2'd0) ? cfg_wdata : m_pend;
    if (m_valid && svc_ready) base[m_idx] = 1'b0;
    if (cfg_wr_en && cfg_wr_sel == 2'd1) m_mask = cfg_wdata;
    if (cfg_wr_en && cfg_wr_sel == 2'd2) m_en = cfg_wdata[12];
    m_pend  = base | setv;
    m_valid = 1'b0;
    m_idx   = 0;
    for (int i = 0; i < 32; i++) begin
      if (!m_valid && m_pend[i] && (i == 0 || (m_en && m_mask[i]))) begin
        m_valid = 1'b1;
        m_idx   = i;
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(svc_valid == m_valid, cur_req, "svc_valid vs model", svc_valid, m_valid);
    if (m_valid) chk(svc_index == m_idx, cur_req, "svc_index vs model", svc_index, m_idx);
    chk(cfg_rdata == m_read(cfg_rd_sel), cur_req, "cfg_rdata vs model",
        cfg_rdata, m_read(cfg_rd_sel));
  endtask

  task automatic wr(bit [1:0] sel, bit [31:0] data);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wdata = data;
    cyc();
    cfg_wr_en = 1'b0;
  endtask

  task automatic expect_svc(bit v, int idx, string req);
    chk(svc_valid == v, req, "svc_valid", svc_valid, v);
    if (v) chk(svc_index == idx, req, "svc_index", svc_index, idx);
  endtask

  task automatic expect_rd(bit [1:0] sel, bit [31:0] exp, string req);
    cfg_rd_sel = sel;
    #1;
    chk(cfg_rdata == exp, req, "cfg_rdata", cfg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; tmr_zero = 1'b0; arith_sticky = '0;
    cfg_wr_en = 1'b0; cfg_wr_sel = '0; cfg_wdata = '0; cfg_rd_sel = '0;
    svc_ready = 1'b0;
    m_pend = '0; m_mask = '0; m_en = 1'b0; m_valid = 1'b0; m_idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    cur_req = "R1";
    expect_svc(1'b0, 0, "R1");
    expect_rd(2'd0, 32'd0, "R1");
    expect_rd(2'd1, 32'd0, "R1");
    expect_rd(2'd2, 32'd0, "R1");
    cfg_rd_sel = 2'd0;
    cyc();

    // R2: masked, disabled request still latches
    cur_req = "R2";
    irq_req = 32'd1 << 9; cyc(); irq_req = '0;
    expect_svc(1'b0, 0, "R2");
    expect_rd(2'd0, 32'd1 << 9, "R2");

    // R6 / R4: unmask without enable, then enable
    cur_req = "R6";
    wr(2'd1, 32'd1 << 9);
    expect_svc(1'b0, 0, "R4");
    wr(2'd2, 32'd1 << 12);
    expect_svc(1'b1, 9, "R6");
    expect_rd(2'd2, 32'd1 << 12, "R4");
    svc_ready = 1'b1; cyc(); svc_ready = 1'b0;
    expect_svc(1'b0, 0, "R9");

    // R3: several requests in one cycle
    cur_req = "R3";
    wr(2'd1, 32'hFFFF_FFFF);
    irq_req = (32'd1 << 20) | (32'd1 << 7) | (32'd1 << 30); cyc(); irq_req = '0;
    expect_svc(1'b1, 7, "R3");
    svc_ready = 1'b1; cyc();
    expect_svc(1'b1, 20, "R3");
    expect_rd(2'd0, (32'd1 << 20) | (32'd1 << 30), "R9");
    cyc();
    expect_svc(1'b1, 30, "R3");
    cyc(); svc_ready = 1'b0;
    expect_svc(1'b0, 0, "R9");
    // R3: preemption by a later higher-priority request
    irq_req = 32'd1 << 15; cyc();
    expect_svc(1'b1, 15, "R3");
    irq_req = 32'd1 << 2; cyc(); irq_req = '0;
    expect_svc(1'b1, 2, "R3");
    svc_ready = 1'b1; cyc(); cyc(); svc_ready = 1'b0;
    expect_svc(1'b0, 0, "R3");

    // R4 / R5: disabled globally and masked; index 0 still serviced
    cur_req = "R4";
    wr(2'd2, 32'd0);
    irq_req = 32'd1 << 3; cyc(); irq_req = '0;
    expect_svc(1'b0, 0, "R4");
    cur_req = "R5";
    wr(2'd1, 32'd0);
    irq_req = 32'd1; cyc(); irq_req = '0;
    expect_svc(1'b1, 0, "R5");
    svc_ready = 1'b1; cyc(); svc_ready = 1'b0;
    wr(2'd2, 32'd1 << 12);
    expect_svc(1'b0, 0, "R6");
    wr(2'd1, 32'hFFFF_FFFF);
    expect_svc(1'b1, 3, "R6");
    svc_ready = 1'b1; cyc(); svc_ready = 1'b0;

    // R7: timer sets two priorities
    cur_req = "R7";
    tmr_zero = 1'b1; cyc(); tmr_zero = 1'b0;
    expect_svc(1'b1, 4, "R7");
    expect_rd(2'd0, (32'd1 << 4) | (32'd1 << 14), "R7");
    svc_ready = 1'b1; cyc();
    expect_svc(1'b1, 14, "R7");
    cyc(); svc_ready = 1'b0;
    expect_svc(1'b0, 0, "R7");

    // R8: sticky flag re-asserts against acknowledge
    cur_req = "R8";
    arith_sticky = 4'b0010; cyc();
    expect_svc(1'b1, 26, "R8");
    svc_ready = 1'b1; cyc();
    expect_svc(1'b1, 26, "R8");
    arith_sticky = '0; cyc(); svc_ready = 1'b0;
    expect_svc(1'b0, 0, "R8");

    // R10: request coincides with acknowledge of same index
    cur_req = "R10";
    irq_req = 32'd1 << 11; cyc();
    expect_svc(1'b1, 11, "R10");
    svc_ready = 1'b1; cyc(); irq_req = '0;
    expect_svc(1'b1, 11, "R10");
    cyc(); svc_ready = 1'b0;
    expect_svc(1'b0, 0, "R10");

    // R11: direct pending writes, set wins over written clear
    cur_req = "R11";
    wr(2'd0, (32'd1 << 5) | (32'd1 << 6));
    expect_svc(1'b1, 5, "R11");
    irq_req = 32'd1 << 6;
    wr(2'd0, 32'd0); irq_req = '0;
    expect_svc(1'b1, 6, "R11");
    expect_rd(2'd0, 32'd1 << 6, "R11");
    wr(2'd0, 32'd0);
    expect_svc(1'b0, 0, "R11");
    cyc();

    finish_run();
  end
endmodule